// File: doc/BRIEF.md
# Data Watchpoint Unit

This unit sits beside the load/store side of a processor pipeline and watches every completed memory-class operation for debug purposes. Each operation arrives as a single-cycle strobe. The strobe carries a 4-bit class code, an effective address, the data word, a byte-lane vector and a transfer length. The unit holds `NWATCH` watchers. Each watcher has a watch address, a watch value and a control word. The control word carries a read enable, a write enable and a per-byte value mask.

An operation can raise one of three debug pulses on a watcher: address-read, address-write or value-match. The operation's class decides which pulse it may raise, through a fixed rule table rather than the direction of the transfer. Some cache maintenance operations count as writes. Touch and instruction-cache block operations count as reads. Operations that act on a whole congruence class never raise anything. A string transfer of length zero is silent.

Once a watcher has a non-zero value mask, it is armed for value compare. From then on it reports only value-match pulses, and these require both the address and the selected data bytes to agree. A simple write port programs the watcher registers.

The unit has no state machine. It is a registered compare stage with two register sets:
- the configuration registers;
- the event output flops, which load the compare result when `op_valid` is high and clear otherwise.

Top module: `dwatch_unit`

## Requirements
- R1: After reset all event outputs are low and every watcher register is zero, so no operation raises an event until a watcher is programmed.
- R2: A write with `cfg_we` high updates watcher `cfg_idx` at the clock edge. Selector 0 writes the watch address and selector 1 writes the watch value. Selector 2 writes the control word: bit 0 is the read enable, bit 1 is the write enable, and bits [XLEN/8+1:2] are the value mask, bit 2 for lane 0. Selector 3 changes nothing.
- R3: An address hit requires `op_addr` and the watch address to agree on every bit above the byte-in-word bits (bits [XLEN-1:2] for XLEN=32).
- R4: Class codes 0 (load), 6 (data touch), 7 (data touch for store), 10 (instruction block invalidate), 11 (instruction touch) and 14 (string load) may only raise read events. Codes 1 (store), 2 (data block invalidate), 3 (data block zero), 4 (data block flush), 5 (data block store-back) and 15 (string store) may only raise write events.
- R5: Codes 8 (data congruence invalidate), 9 (data cache read), 12 (instruction congruence invalidate) and 13 (instruction cache read) never raise any event.
- R6: Codes 14 and 15 with `op_len` equal to zero raise no event of any kind.
- R7: On an unarmed watcher, `ev_rd` pulses for a read-capable class that hits with the read enable set. `ev_wr` pulses for a write-capable class that hits with the write enable set.
- R8: A watcher is armed when at least one of its two enables is set and its mask is non-zero. An armed watcher never raises `ev_rd` or `ev_wr`. It raises `ev_dvc` exactly when R7 would have raised a pulse and the value matches.
- R9: The value matches when every lane i selected in the mask has `op_lanes[i]` set and `op_data[8i+7:8i]` equal to byte i of the watch value. Unselected lanes are ignored.
- R10: Events are one-cycle pulses registered on the edge that samples `op_valid`. No event follows a cycle with `op_valid` low.
- R11: In any cycle a watcher raises at most one of its three events.
- R12: Watchers are evaluated independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Watcher selected for the write |
| cfg_sel | input | 2 | Register selector: 0 address, 1 value, 2 control, 3 none |
| cfg_wdata | input | XLEN | Configuration write data |
| op_valid | input | 1 | Completed operation strobe |
| op_class | input | 4 | Operation class code |
| op_addr | input | XLEN | Effective address |
| op_data | input | XLEN | Data value, lane i in bits [8i+7:8i] |
| op_lanes | input | XLEN/8 | Byte lanes carried by the access |
| op_len | input | LEN_W | Transfer length (used for string classes) |
| ev_rd | output | NWATCH | Address-read event pulse per watcher |
| ev_wr | output | NWATCH | Address-write event pulse per watcher |
| ev_dvc | output | NWATCH | Value-match event pulse per watcher |

## Verification
The assertions check the following on every cycle:
- the pulse discipline: nothing follows an idle cycle, and at most one event per watcher;
- the silence of congruence-class and zero-length string operations;
- that an armed watcher never emits a plain address pulse;
- that a watcher with both enables clear stays quiet;
- that selector 3 leaves the registers untouched.

Some behaviour only the bench's scenarios can show:
- that each class code maps to the correct read or write side;
- that the address compare ignores exactly the byte-in-word bits;
- that value match needs every masked lane to be present and equal;
- that one watcher's programming leaves the other's results unchanged.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;

    typedef enum logic [3:0] {
        OP_LOAD       = 4'd0,
        OP_STORE      = 4'd1,
        OP_DBLK_INV   = 4'd2,
        OP_DBLK_ZERO  = 4'd3,
        OP_DBLK_FLUSH = 4'd4,
        OP_DBLK_STORE = 4'd5,
        OP_DTOUCH     = 4'd6,
        OP_DTOUCH_ST  = 4'd7,
        OP_DCC_INV    = 4'd8,
        OP_DREAD      = 4'd9,
        OP_IBLK_INV   = 4'd10,
        OP_ITOUCH     = 4'd11,
        OP_ICC_INV    = 4'd12,
        OP_IREAD      = 4'd13,
        OP_STR_LOAD   = 4'd14,
        OP_STR_STORE  = 4'd15
    } op_class_e;

    typedef enum logic [1:0] {
        REG_ADDR  = 2'd0,
        REG_VALUE = 2'd1,
        REG_CTRL  = 2'd2,
        REG_NONE  = 2'd3
    } cfg_sel_e;

    // Which side of the compare a class may reach
    typedef struct packed {
        logic rd;
        logic wr;
    } ev_side_t;

endpackage

// File: rtl/dwatch_classify.sv
module dwatch_classify
    import dwatch_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic [3:0]       op_class,
    input  logic [LEN_W-1:0] op_len,
    output ev_side_t         side
);

    ev_side_t base;
    logic     is_string;

    always_comb begin
        base      = '{rd: 1'b0, wr: 1'b0};
        is_string = 1'b0;
        unique case (op_class_e'(op_class))
            OP_LOAD, OP_DTOUCH, OP_DTOUCH_ST,
            OP_IBLK_INV, OP_ITOUCH:             base.rd = 1'b1;
            OP_STR_LOAD: begin
                base.rd   = 1'b1;
                is_string = 1'b1;
            end
            OP_STORE, OP_DBLK_INV, OP_DBLK_ZERO,
            OP_DBLK_FLUSH, OP_DBLK_STORE:       base.wr = 1'b1;
            OP_STR_STORE: begin
                base.wr   = 1'b1;
                is_string = 1'b1;
            end
            OP_DCC_INV, OP_DREAD,
            OP_ICC_INV, OP_IREAD:               base = '{rd: 1'b0, wr: 1'b0};
            default:                            base = '{rd: 1'b0, wr: 1'b0};
        endcase
    end

    // A zero-length string transfer touches no storage
    assign side = (is_string && op_len == '0) ? '{rd: 1'b0, wr: 1'b0} : base;

endmodule

// File: rtl/dwatch_cfg_regs.sv
module dwatch_cfg_regs
    import dwatch_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NWATCH = 2,
    parameter int IDX_W  = 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [IDX_W-1:0]                  cfg_idx,
    input  logic [1:0]                        cfg_sel,
    input  logic [XLEN-1:0]                   cfg_wdata,
    output logic [NWATCH-1:0][XLEN-1:0]       w_addr,
    output logic [NWATCH-1:0][XLEN-1:0]       w_val,
    output logic [NWATCH-1:0]                 w_rd_en,
    output logic [NWATCH-1:0]                 w_wr_en,
    output logic [NWATCH-1:0][XLEN/8-1:0]     w_mask
);

    localparam int NL     = XLEN / 8;
    localparam int CTRL_W = NL + 2;

    logic [XLEN-1:CTRL_W] unused_ctrl_hi;
    assign unused_ctrl_hi = cfg_wdata[XLEN-1:CTRL_W];

    for (genvar g = 0; g < NWATCH; g++) begin : g_watch
        logic            sel_me;
        logic [XLEN-1:0] addr_q;
        logic [XLEN-1:0] val_q;
        logic            rd_q;
        logic            wr_q;
        logic [NL-1:0]   mask_q;

        assign sel_me = cfg_we && (cfg_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q <= '0;
                val_q  <= '0;
                rd_q   <= 1'b0;
                wr_q   <= 1'b0;
                mask_q <= '0;
            end else if (sel_me) begin
                unique case (cfg_sel_e'(cfg_sel))
                    REG_ADDR:  addr_q <= cfg_wdata;
                    REG_VALUE: val_q  <= cfg_wdata;
                    REG_CTRL: begin
                        rd_q   <= cfg_wdata[0];
                        wr_q   <= cfg_wdata[1];
                        mask_q <= cfg_wdata[CTRL_W-1:2];
                    end
                    REG_NONE:  ;
                    default:   ;
                endcase
            end
        end

        assign w_addr[g]  = addr_q;
        assign w_val[g]   = val_q;
        assign w_rd_en[g] = rd_q;
        assign w_wr_en[g] = wr_q;
        assign w_mask[g]  = mask_q;
    end

    // R2: selector 3 leaves every watcher register untouched
    a_r2_none_sel_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd3) |=>
            ($stable(w_addr) && $stable(w_val) && $stable(w_rd_en)
             && $stable(w_wr_en) && $stable(w_mask)));

endmodule

// File: rtl/dwatch_cmp.sv
module dwatch_cmp
    import dwatch_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   op_addr,
    input  logic [XLEN-1:0]   op_data,
    input  logic [XLEN/8-1:0] op_lanes,
    input  ev_side_t          side,
    input  logic [XLEN-1:0]   w_addr,
    input  logic [XLEN-1:0]   w_val,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [XLEN/8-1:0] w_mask,
    output logic              hit_rd,
    output logic              hit_wr,
    output logic              hit_dvc
);

    localparam int NL = XLEN / 8;
    localparam int LB = $clog2(NL);

    logic [LB-1:0] unused_lo_op;
    logic [LB-1:0] unused_lo_w;
    assign unused_lo_op = op_addr[LB-1:0];
    assign unused_lo_w  = w_addr[LB-1:0];

    logic          addr_hit;
    logic [NL-1:0] lane_ok;
    logic          armed;
    logic          rd_cand;
    logic          wr_cand;

    assign addr_hit = (op_addr[XLEN-1:LB] == w_addr[XLEN-1:LB]);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        assign lane_ok[i] = !w_mask[i]
                          || (op_lanes[i] && op_data[8*i +: 8] == w_val[8*i +: 8]);
    end

    assign armed   = (rd_en || wr_en) && (|w_mask);
    assign rd_cand = addr_hit && side.rd && rd_en;
    assign wr_cand = addr_hit && side.wr && wr_en;

    assign hit_rd  = rd_cand && !armed;
    assign hit_wr  = wr_cand && !armed;
    assign hit_dvc = armed && (rd_cand || wr_cand) && (&lane_ok);

endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
    import dwatch_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NWATCH = 2,
    parameter int LEN_W  = 7,
    parameter int IDX_W  = (NWATCH > 1) ? $clog2(NWATCH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [1:0]          cfg_sel,
    input  logic [XLEN-1:0]     cfg_wdata,
    input  logic                op_valid,
    input  logic [3:0]          op_class,
    input  logic [XLEN-1:0]     op_addr,
    input  logic [XLEN-1:0]     op_data,
    input  logic [XLEN/8-1:0]   op_lanes,
    input  logic [LEN_W-1:0]    op_len,
    output logic [NWATCH-1:0]   ev_rd,
    output logic [NWATCH-1:0]   ev_wr,
    output logic [NWATCH-1:0]   ev_dvc
);

    localparam int NL = XLEN / 8;

    logic [NWATCH-1:0][XLEN-1:0] w_addr;
    logic [NWATCH-1:0][XLEN-1:0] w_val;
    logic [NWATCH-1:0]           w_rd_en;
    logic [NWATCH-1:0]           w_wr_en;
    logic [NWATCH-1:0][NL-1:0]   w_mask;
    ev_side_t                    side;
    logic [NWATCH-1:0]           hit_rd;
    logic [NWATCH-1:0]           hit_wr;
    logic [NWATCH-1:0]           hit_dvc;

    dwatch_cfg_regs #(.XLEN(XLEN), .NWATCH(NWATCH), .IDX_W(IDX_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .w_addr    (w_addr),
        .w_val     (w_val),
        .w_rd_en   (w_rd_en),
        .w_wr_en   (w_wr_en),
        .w_mask    (w_mask)
    );

    dwatch_classify #(.LEN_W(LEN_W)) u_cls (
        .op_class (op_class),
        .op_len   (op_len),
        .side     (side)
    );

    for (genvar w = 0; w < NWATCH; w++) begin : g_cmp
        dwatch_cmp #(.XLEN(XLEN)) u_cmp (
            .op_addr  (op_addr),
            .op_data  (op_data),
            .op_lanes (op_lanes),
            .side     (side),
            .w_addr   (w_addr[w]),
            .w_val    (w_val[w]),
            .rd_en    (w_rd_en[w]),
            .wr_en    (w_wr_en[w]),
            .w_mask   (w_mask[w]),
            .hit_rd   (hit_rd[w]),
            .hit_wr   (hit_wr[w]),
            .hit_dvc  (hit_dvc[w])
        );
    end

    // Event output flops: load on a valid operation, clear otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_rd  <= '0;
            ev_wr  <= '0;
            ev_dvc <= '0;
        end else if (op_valid) begin
            ev_rd  <= hit_rd;
            ev_wr  <= hit_wr;
            ev_dvc <= hit_dvc;
        end else begin
            ev_rd  <= '0;
            ev_wr  <= '0;
            ev_dvc <= '0;
        end
    end

    // R10: nothing follows an idle cycle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (ev_rd == '0 && ev_wr == '0 && ev_dvc == '0));

    // R5: congruence-class operations are silent
    a_r5_cc_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_class == 4'd8 || op_class == 4'd9
                      || op_class == 4'd12 || op_class == 4'd13))
        |=> (ev_rd == '0 && ev_wr == '0 && ev_dvc == '0));

    // R6: zero-length string transfers are silent
    a_r6_zero_string: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class[3:1] == 3'b111 && op_len == '0)
        |=> (ev_rd == '0 && ev_wr == '0 && ev_dvc == '0));

    for (genvar w = 0; w < NWATCH; w++) begin : g_chk
        // R11: at most one event per watcher
        a_r11_one_event: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({ev_rd[w], ev_wr[w], ev_dvc[w]}));

        // R8: an armed watcher never emits a plain address pulse
        a_r8_armed_no_plain: assert property (@(posedge clk) disable iff (!rst_n)
            ((w_rd_en[w] || w_wr_en[w]) && (|w_mask[w]) && !cfg_we)
            |=> (!ev_rd[w] && !ev_wr[w]));

        // R1: a watcher with both enables clear stays quiet
        a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (!w_rd_en[w] && !w_wr_en[w] && !cfg_we)
            |=> (!ev_rd[w] && !ev_wr[w] && !ev_dvc[w]));
    end

endmodule

// File: tb/dwatch_unit_bench.sv
`timescale 1ns/1ps
module dwatch_unit_bench;

    localparam int XLEN = 32;
    localparam int NW   = 2;
    localparam int NL   = 4;
    localparam int LW   = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [0:0]      cfg_idx = '0;
    logic [1:0]      cfg_sel = '0;
    logic [31:0]     cfg_wdata = '0;
    logic            op_valid = 1'b0;
    logic [3:0]      op_class = '0;
    logic [31:0]     op_addr = '0;
    logic [31:0]     op_data = '0;
    logic [NL-1:0]   op_lanes = '0;
    logic [LW-1:0]   op_len = '0;
    logic [NW-1:0]   ev_rd;
    logic [NW-1:0]   ev_wr;
    logic [NW-1:0]   ev_dvc;

    dwatch_unit #(.XLEN(XLEN), .NWATCH(NW), .LEN_W(LW)) u_dwatch_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .op_valid(op_valid),
        .op_class(op_class), .op_addr(op_addr), .op_data(op_data),
        .op_lanes(op_lanes), .op_len(op_len), .ev_rd(ev_rd), .ev_wr(ev_wr),
        .ev_dvc(ev_dvc)
    );

    always #2 clk = ~clk;

    logic [31:0]   m_addr [NW];
    logic [31:0]   m_val  [NW];
    logic          m_rd   [NW];
    logic          m_wr   [NW];
    logic [NL-1:0] m_mask [NW];
    int n_cmp = 0;
    int n_bad = 0;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic cfg_write(int idx, logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 1'(idx); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            2'd0: m_addr[idx] = d;
            2'd1: m_val[idx]  = d;
            2'd2: begin m_rd[idx] = d[0]; m_wr[idx] = d[1]; m_mask[idx] = d[5:2]; end
            default: ;
        endcase
    endtask

    // Reference result for one watcher: {dvc, wr, rd}
    function automatic logic [2:0] ref_one(int w, logic [3:0] c, logic [31:0] a,
                                          logic [31:0] d, logic [NL-1:0] ln,
                                          logic [LW-1:0] len);
        logic rc, wc, hit, armed, vm, er, ew;
        rc = (c == 0 || c == 6 || c == 7 || c == 10 || c == 11 || c == 14);
        wc = (c == 1 || c == 2 || c == 3 || c == 4 || c == 5 || c == 15);
        if ((c == 14 || c == 15) && len == 0) begin rc = 0; wc = 0; end
        hit   = (a[31:2] == m_addr[w][31:2]);
        armed = (m_rd[w] || m_wr[w]) && (m_mask[w] != 0);
        vm = 1'b1;
        for (int i = 0; i < NL; i++)
            if (m_mask[w][i] && (!ln[i] || d[8*i +: 8] != m_val[w][8*i +: 8])) vm = 1'b0;
        er = hit && rc && m_rd[w];
        ew = hit && wc && m_wr[w];
        if (armed) return {(er || ew) && vm, 1'b0, 1'b0};
        return {1'b0, ew, er};
    endfunction

    task automatic check_out(string req, logic [NW-1:0] xr, logic [NW-1:0] xw,
                             logic [NW-1:0] xd);
        n_cmp++;
        if (ev_rd !== xr || ev_wr !== xw || ev_dvc !== xd) begin
            n_bad++;
            $display("FAIL %s: rd=%b wr=%b dvc=%b expected rd=%b wr=%b dvc=%b",
                     req, ev_rd, ev_wr, ev_dvc, xr, xw, xd);
        end
    endtask

    task automatic run_op(string req, logic [3:0] c, logic [31:0] a, logic [31:0] d,
                          logic [NL-1:0] ln, logic [LW-1:0] len);
        logic [NW-1:0] xr, xw, xd;
        for (int w = 0; w < NW; w++) begin
            logic [2:0] r;
            r = ref_one(w, c, a, d, ln, len);
            xd[w] = r[2]; xw[w] = r[1]; xr[w] = r[0];
        end
        @(negedge clk);
        op_valid = 1'b1; op_class = c; op_addr = a; op_data = d;
        op_lanes = ln; op_len = len;
        @(negedge clk);
        op_valid = 1'b0;
        check_out(req, xr, xw, xd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog expired: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h0dd5eed));
        for (int w = 0; w < NW; w++) begin
            m_addr[w] = '0; m_val[w] = '0; m_rd[w] = 0; m_wr[w] = 0; m_mask[w] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 reset outputs", '0, '0, '0);
        run_op("R1 unprogrammed load", 4'd0, 32'h0, 32'h0, 4'hF, 7'd4);

        // Directed: watcher 0 read only
        cfg_write(0, 2'd0, 32'h1000_0040);
        cfg_write(0, 2'd2, 32'h1);
        run_op("R3 R7 load hit", 4'd0, 32'h1000_0042, 32'h5, 4'hF, 7'd4);
        @(negedge clk);
        check_out("R10 pulse one cycle", '0, '0, '0);
        run_op("R3 miss next word", 4'd0, 32'h1000_0044, 32'h5, 4'hF, 7'd4);
        run_op("R4 store not read side", 4'd1, 32'h1000_0040, 32'h5, 4'hF, 7'd4);
        cfg_write(0, 2'd2, 32'h3);
        run_op("R4 block flush is write", 4'd4, 32'h1000_0040, 0, 4'hF, 7'd4);
        run_op("R4 block zero is write", 4'd3, 32'h1000_0040, 0, 4'hF, 7'd4);
        run_op("R4 touch is read", 4'd6, 32'h1000_0040, 0, 4'hF, 7'd4);
        run_op("R4 icache block inv is read", 4'd10, 32'h1000_0040, 0, 4'hF, 7'd4);
        for (int c = 8; c < 14; c++)
            if (c != 10 && c != 11)
                run_op("R5 congruence silent", 4'(c), 32'h1000_0040, 0, 4'hF, 7'd4);
        run_op("R6 zero string store", 4'd15, 32'h1000_0040, 0, 4'hF, 7'd0);
        run_op("R6 zero string load", 4'd14, 32'h1000_0040, 0, 4'hF, 7'd0);
        run_op("R4 string store len 4", 4'd15, 32'h1000_0040, 0, 4'hF, 7'd4);
        cfg_write(0, 2'd3, 32'hFFFF_FFFF);
        run_op("R2 selector 3 ignored", 4'd0, 32'h1000_0040, 0, 4'hF, 7'd4);

        // Value compare on watcher 0, lanes 0 and 1
        cfg_write(0, 2'd1, 32'hAABB_CCDD);
        cfg_write(0, 2'd2, 32'h3 | (32'h3 << 2));
        run_op("R8 R9 value match", 4'd0, 32'h1000_0040, 32'h1234_CCDD, 4'hF, 7'd4);
        run_op("R8 value mismatch", 4'd1, 32'h1000_0040, 32'h1234_CCDE, 4'hF, 7'd4);
        run_op("R9 lane missing", 4'd0, 32'h1000_0040, 32'h1234_CCDD, 4'hC, 7'd4);
        run_op("R8 address miss", 4'd0, 32'h1000_0080, 32'h1234_CCDD, 4'hF, 7'd4);

        // Watcher 1 independent
        cfg_write(1, 2'd0, 32'h2000_0100);
        cfg_write(1, 2'd2, 32'h2);
        run_op("R12 watcher 1 store", 4'd1, 32'h2000_0100, 0, 4'hF, 7'd4);
        run_op("R12 watcher 0 untouched", 4'd0, 32'h1000_0040, 32'hCCDD, 4'h3, 7'd2);

        // Random mix
        for (int n = 0; n < 800; n++) begin
            int w;
            logic [31:0] a, d;
            logic [NL-1:0] ln;
            logic [LW-1:0] len;
            if (n % 25 == 0)
                for (int k = 0; k < NW; k++) begin
                    logic [NL-1:0] mk;
                    mk = ($urandom % 4 == 0) ? '0 : 4'($urandom);
                    cfg_write(k, 2'd0, 32'h2000_0000 | ($urandom & 32'hFC));
                    cfg_write(k, 2'd1, $urandom);
                    cfg_write(k, 2'd2, {26'b0, mk, 2'($urandom)});
                end
            w = int'($urandom % NW);
            a = ($urandom % 2 == 1) ? {m_addr[w][31:2], 2'($urandom)}
                                    : (32'h2000_0000 | ($urandom & 32'hFF));
            if ($urandom % 2 == 1)
                d = m_val[w] ^ (($urandom % 4 == 0) ? (32'hFF << (8 * ($urandom % 4))) : 32'h0);
            else
                d = $urandom;
            ln  = ($urandom % 3 == 0) ? 4'($urandom) : 4'hF;
            len = ($urandom % 4 == 0) ? '0 : 7'($urandom);
            run_op("R3 R4 R7 R8 R9 R12 random", 4'($urandom), a, d, ln, len);
        end

        @(negedge clk);
        check_out("R10 idle after traffic", '0, '0, '0);
        summary();
        $finish;
    end

endmodule